// File: doc/BRIEF.md
# Two-Pass Fixed-Point 8x8 Inverse DCT Engine

This block turns an 8x8 block of signed 16-bit dequantized coefficients into 64 signed 8-bit samples. It runs two one-dimensional transform passes against a signed 16-bit 8x8 coefficient matrix, which is held in a register array that can be loaded. Coefficients and matrix entries are written one per cycle through addressed write ports while the engine is idle. A start pulse then launches the transform. A single shared multiply-accumulate unit computes all 128 dot products of the block, eight products each. After both passes, the block streams the 64 results out on consecutive cycles with a valid strobe. It then raises a one-cycle done flag.

The first pass stores its results transposed as signed 16-bit values. The second pass reads that intermediate block and reduces each result to 9 significant bits. It then saturates the value to the signed 8-bit range. A block index, captured at start, labels the streamed results with a destination tag: red-difference chroma, blue-difference chroma or luma. A decoder walks the indices 0 to 5 for each macroblock. Done never rises earlier than a parameterised minimum cycle count after start, which models a fixed per-block cost.

The controller is a state machine with six states:
- IDLE: waits; a start pulse moves it to PASS_ONE.
- PASS_ONE: runs 512 MAC steps, then moves to PASS_TWO.
- PASS_TWO: runs 512 MAC steps, then moves to EMIT.
- EMIT: streams 64 cycles of output, then moves to SETTLE.
- SETTLE: holds until the minimum cycle count is met, then moves to FINISH.
- FINISH: asserts done for one cycle, then returns to IDLE.

Top module: `idct8x8_core`

## Requirements
- R1: After reset, busy, done and out_valid are all low.
- R2: A matrix write (mat_we) while idle stores mat_data as entry u of matrix row x, at address x*8+u. A matrix write while busy has no effect.
- R3: A coefficient write (cf_we) while idle stores cf_data as element u of input row c, at address c*8+u. A coefficient write while busy has no effect.
- R4: Pass one forms each result for input row c and matrix row x as follows:
  - Sum the products in[c*8+u]*M[x*8+u] over u = 0..7, in 32-bit wrapping signed arithmetic.
  - Add 16384 and shift arithmetically right by 15.
  - Truncate to 16 bits and store at intermediate position x*8+c (transposed).
- R5: Pass two applies the same sum and rounding to the intermediate rows and stores each result at position c*8+x. Before storing, it keeps the low 9 bits as a signed value and saturates that to the range -128..127.
- R6: After both passes, out_valid stays high for exactly 64 consecutive cycles. During these cycles out_idx counts 0 to 63 and out_data carries the result stored at that position.
- R7: out_blk carries the block index captured at start. out_tag is 0 for index 0 (red-difference chroma), 1 for index 1 (blue-difference chroma) and 2 (luma) for indices 2 to 7.
- R8: done is a one-cycle pulse after the readout. It rises no sooner than MIN_CYCLES clock edges after the edge that accepted start, and busy is low in the cycle after done.
- R9: A start pulse while busy is ignored: the running block, its index and its results are unchanged, and no second transform follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mat_we | input | 1 | Matrix entry write strobe |
| mat_addr | input | 6 | Matrix entry address (row*8 + column) |
| mat_data | input | 16 | Signed matrix entry |
| cf_we | input | 1 | Coefficient write strobe |
| cf_addr | input | 6 | Coefficient address (row*8 + column) |
| cf_data | input | 16 | Signed coefficient |
| start | input | 1 | Start pulse, accepted only while idle |
| blk_idx | input | 3 | Block index captured at start |
| busy | output | 1 | High from start acceptance to the done cycle |
| done | output | 1 | One-cycle completion pulse |
| out_valid | output | 1 | Result strobe |
| out_idx | output | 6 | Position of the streamed result |
| out_data | output | 8 | Signed 8-bit result |
| out_tag | output | 2 | Destination tag: 0 red chroma, 1 blue chroma, 2 luma |
| out_blk | output | 3 | Captured block index |

## Verification
The bench builds the block with an 8x8 block, 16-bit data, 8-bit results, a 32-bit accumulator and a 15-bit shift. It sets MIN_CYCLES to 1200, above the roughly 1090 cycles that computation and readout take, so the SETTLE hold state is actually entered. This lets the bench measure that done waits for the minimum count rather than following the readout. Three matrix families drive both the 9-bit mask and the saturation corner:
- an identity-like matrix;
- a dense random matrix;
- a full-scale diagonal matrix with extreme coefficients.

A non-symmetric matrix exposes any mistake in the transpose point of pass one.

// File: rtl/idct_pkg.sv
package idct_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PASS_ONE = 3'd1,
        S_PASS_TWO = 3'd2,
        S_EMIT     = 3'd3,
        S_SETTLE   = 3'd4,
        S_FINISH   = 3'd5
    } idct_state_t;

    typedef enum logic [1:0] {
        TAG_CR   = 2'd0,
        TAG_CB   = 2'd1,
        TAG_LUMA = 2'd2
    } blk_tag_t;

endpackage

// File: rtl/idct_regfile.sv
module idct_regfile #(
    parameter int W     = 16,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [DEPTH-1:0][W-1:0] mem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // Guards R2 and R3: the top gates the write enable with busy.
    p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem))
        else $error("storage changed without a write enable");

endmodule

// File: rtl/idct_mac.sv
module idct_mac #(
    parameter int DW    = 16,
    parameter int OW    = 8,
    parameter int ACC_W = 32,
    parameter int FRAC  = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic signed [DW-1:0]    a,
    input  logic signed [DW-1:0]    b,
    output logic signed [DW-1:0]    res_wide,
    output logic signed [OW-1:0]    res_sat
);
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [OW:0]      HI  = {2'b00, {(OW-1){1'b1}}};
    localparam logic signed [OW:0]      LO  = {2'b11, {(OW-1){1'b0}}};

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] shifted;
    logic signed [OW:0]      m9;

    always_comb begin
        prod     = ACC_W'(a) * ACC_W'(b);
        sum      = (first ? '0 : acc) + prod;
        shifted  = (sum + RND) >>> FRAC;
        res_wide = shifted[DW-1:0];
        m9       = shifted[OW:0];
        if (m9 > HI) begin
            res_sat = HI[OW-1:0];
        end else if (m9 < LO) begin
            res_sat = LO[OW-1:0];
        end else begin
            res_sat = m9[OW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum;
        end
    end

    // R4: the first step of every dot product starts from the bare product.
    p_acc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && first) |=> acc == $past(prod))
        else $error("accumulator did not restart on first step");

endmodule

// File: rtl/idct_ctrl.sv
module idct_ctrl
    import idct_pkg::*;
#(
    parameter int N          = 8,
    parameter int MIN_CYCLES = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [2:0]                 blk_in,
    output logic                       busy,
    output logic                       done,
    output logic                       out_valid,
    output logic [2*$clog2(N)-1:0]     out_idx,
    output logic [2:0]                 blk_q,
    output logic                       pass_two,
    output logic                       mac_en,
    output logic                       mac_first,
    output logic [2*$clog2(N)-1:0]     a_addr,
    output logic [2*$clog2(N)-1:0]     b_addr,
    output logic                       mid_we,
    output logic [2*$clog2(N)-1:0]     mid_waddr,
    output logic                       res_we,
    output logic [2*$clog2(N)-1:0]     res_waddr
);
    localparam int IW  = $clog2(N);
    localparam int AW  = 2 * IW;
    localparam int SW  = 3 * IW;
    localparam int CCW = $clog2(MIN_CYCLES + 1);

    idct_state_t      state, state_nx;
    logic [SW-1:0]    step;
    logic [AW-1:0]    emit_cnt;
    logic [CCW-1:0]   cyc_cnt;
    logic [IW-1:0]    row_c, row_x, col_u;
    logic             step_last, emit_last, min_met, u_last;

    assign row_c     = step[SW-1 -: IW];
    assign row_x     = step[AW-1 -: IW];
    assign col_u     = step[IW-1:0];
    assign step_last = (step == {SW{1'b1}});
    assign emit_last = (emit_cnt == {AW{1'b1}});
    assign u_last    = (col_u == {IW{1'b1}});
    assign min_met   = (cyc_cnt == CCW'(MIN_CYCLES));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start)     state_nx = S_PASS_ONE;
            S_PASS_ONE: if (step_last) state_nx = S_PASS_TWO;
            S_PASS_TWO: if (step_last) state_nx = S_EMIT;
            S_EMIT:     if (emit_last) state_nx = S_SETTLE;
            S_SETTLE:   if (min_met)   state_nx = S_FINISH;
            S_FINISH:                  state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    // Counters and captured block index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= '0;
            emit_cnt <= '0;
            cyc_cnt  <= '0;
            blk_q    <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                blk_q   <= blk_in;
                cyc_cnt <= '0;
            end else if (state != S_IDLE && !min_met) begin
                cyc_cnt <= cyc_cnt + 1'b1;
            end
            if (state == S_PASS_ONE || state == S_PASS_TWO) begin
                step <= step + 1'b1;
            end else begin
                step <= '0;
            end
            if (state == S_EMIT) begin
                emit_cnt <= emit_cnt + 1'b1;
            end else begin
                emit_cnt <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        out_valid = (state == S_EMIT);
        out_idx   = emit_cnt;
        pass_two  = (state == S_PASS_TWO);
        mac_en    = (state == S_PASS_ONE) || (state == S_PASS_TWO);
        mac_first = (col_u == '0);
        a_addr    = {row_c, col_u};
        b_addr    = {row_x, col_u};
        mid_we    = (state == S_PASS_ONE) && u_last;
        mid_waddr = {row_x, row_c};
        res_we    = (state == S_PASS_TWO) && u_last;
        res_waddr = {row_c, row_x};
    end

    p_emit_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_idx == AW'($past(out_idx) + 1'b1))
        else $error("readout order broken");

    p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, done, mid_we, res_we}))
        else $error("overlapping phases");

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy && $stable(blk_q)))
        else $error("start accepted while busy");

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy)
        else $error("busy after done");

endmodule

// File: rtl/idct8x8_core.sv
module idct8x8_core
    import idct_pkg::*;
#(
    parameter int N          = 8,
    parameter int DW         = 16,
    parameter int OW         = 8,
    parameter int ACC_W      = 32,
    parameter int FRAC       = 15,
    parameter int MIN_CYCLES = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mat_we,
    input  logic [2*$clog2(N)-1:0]     mat_addr,
    input  logic [DW-1:0]              mat_data,
    input  logic                       cf_we,
    input  logic [2*$clog2(N)-1:0]     cf_addr,
    input  logic [DW-1:0]              cf_data,
    input  logic                       start,
    input  logic [2:0]                 blk_idx,
    output logic                       busy,
    output logic                       done,
    output logic                       out_valid,
    output logic [2*$clog2(N)-1:0]     out_idx,
    output logic [OW-1:0]              out_data,
    output logic [1:0]                 out_tag,
    output logic [2:0]                 out_blk
);
    localparam int AW    = 2 * $clog2(N);
    localparam int DEPTH = N * N;
    localparam int WCW   = $clog2(MIN_CYCLES + 1);

    logic          pass_two, mac_en, mac_first, mid_we, res_we;
    logic [AW-1:0] a_addr, b_addr, mid_waddr, res_waddr;
    logic [DW-1:0] cf_rd, mid_rd, mat_rd, a_op, res_wide;
    logic [OW-1:0] res_sat;
    logic [2:0]    blk_q;
    blk_tag_t      tag;

    idct_ctrl #(.N(N), .MIN_CYCLES(MIN_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_in(blk_idx),
        .busy(busy), .done(done), .out_valid(out_valid), .out_idx(out_idx),
        .blk_q(blk_q), .pass_two(pass_two), .mac_en(mac_en), .mac_first(mac_first),
        .a_addr(a_addr), .b_addr(b_addr), .mid_we(mid_we), .mid_waddr(mid_waddr),
        .res_we(res_we), .res_waddr(res_waddr)
    );

    idct_regfile #(.W(DW), .DEPTH(DEPTH)) u_matrix (
        .clk(clk), .rst_n(rst_n), .we(mat_we && !busy), .waddr(mat_addr),
        .wdata(mat_data), .raddr(b_addr), .rdata(mat_rd)
    );

    idct_regfile #(.W(DW), .DEPTH(DEPTH)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(cf_we && !busy), .waddr(cf_addr),
        .wdata(cf_data), .raddr(a_addr), .rdata(cf_rd)
    );

    idct_regfile #(.W(DW), .DEPTH(DEPTH)) u_mid (
        .clk(clk), .rst_n(rst_n), .we(mid_we), .waddr(mid_waddr),
        .wdata(res_wide), .raddr(a_addr), .rdata(mid_rd)
    );

    idct_regfile #(.W(OW), .DEPTH(DEPTH)) u_result (
        .clk(clk), .rst_n(rst_n), .we(res_we), .waddr(res_waddr),
        .wdata(res_sat), .raddr(out_idx), .rdata(out_data)
    );

    assign a_op = pass_two ? mid_rd : cf_rd;

    idct_mac #(.DW(DW), .OW(OW), .ACC_W(ACC_W), .FRAC(FRAC)) u_mac (
        .clk(clk), .rst_n(rst_n), .en(mac_en), .first(mac_first),
        .a(a_op), .b(mat_rd), .res_wide(res_wide), .res_sat(res_sat)
    );

    always_comb begin
        unique case (blk_q)
            3'd0:    tag = TAG_CR;
            3'd1:    tag = TAG_CB;
            default: tag = TAG_LUMA;
        endcase
        out_tag = tag;
        out_blk = blk_q;
    end

    // Independent window counter for the minimum-latency check
    logic [WCW-1:0] watch_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            watch_cnt <= '0;
        end else if (start && !busy) begin
            watch_cnt <= '0;
        end else if (watch_cnt != WCW'(MIN_CYCLES)) begin
            watch_cnt <= watch_cnt + 1'b1;
        end
    end

    p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> watch_cnt == WCW'(MIN_CYCLES))
        else $error("done before minimum latency");

endmodule

// File: tb/idct8x8_core_tb.sv
module idct8x8_core_tb;
    localparam int MINC = 1200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mat_we = 1'b0, cf_we = 1'b0, start = 1'b0;
    logic [5:0] mat_addr = '0, cf_addr = '0;
    logic [15:0] mat_data = '0, cf_data = '0;
    logic [2:0] blk_idx = '0;
    logic busy, done, out_valid;
    logic [5:0] out_idx;
    logic [7:0] out_data;
    logic [1:0] out_tag;
    logic [2:0] out_blk;

    int n_chk = 0, n_fail = 0;
    shortint mat_m[64];
    shortint cf_m[64];
    int exp_v[64];

    always #10 clk = ~clk;

    idct8x8_core #(.MIN_CYCLES(MINC)) u_dut (
        .clk(clk), .rst_n(rst_n), .mat_we(mat_we), .mat_addr(mat_addr),
        .mat_data(mat_data), .cf_we(cf_we), .cf_addr(cf_addr), .cf_data(cf_data),
        .start(start), .blk_idx(blk_idx), .busy(busy), .done(done),
        .out_valid(out_valid), .out_idx(out_idx), .out_data(out_data),
        .out_tag(out_tag), .out_blk(out_blk)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int sat9(input int v);
        int m = v & 511;
        if (m >= 256) m -= 512;
        if (m > 127) return 127;
        if (m < -128) return -128;
        return m;
    endfunction

    // Behavioural model of the two passes (R4, R5)
    task automatic model();
        shortint mid[64];
        for (int c = 0; c < 8; c++) begin
            for (int x = 0; x < 8; x++) begin
                int s = 0;
                for (int u = 0; u < 8; u++) s += int'(cf_m[c*8+u]) * int'(mat_m[x*8+u]);
                mid[x*8+c] = shortint'((s + 16384) >>> 15);
            end
        end
        for (int c = 0; c < 8; c++) begin
            for (int x = 0; x < 8; x++) begin
                int s = 0;
                for (int u = 0; u < 8; u++) s += int'(mid[c*8+u]) * int'(mat_m[x*8+u]);
                exp_v[c*8+x] = sat9((s + 16384) >>> 15);
            end
        end
    endtask

    task automatic load_all();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            mat_we = 1'b1; mat_addr = 6'(i); mat_data = mat_m[i];
            cf_we = 1'b1;  cf_addr = 6'(i);  cf_data = cf_m[i];
        end
        @(negedge clk);
        mat_we = 1'b0; cf_we = 1'b0;
    endtask

    // Runs one block; optionally disturbs it mid-run with start and writes.
    task automatic run_block(input int idx, input bit disturb, input string tname);
        int n = 0, nvalid = 0, exp_tag;
        bit seen_done = 0;
        exp_tag = (idx == 0) ? 0 : (idx == 1) ? 1 : 2;
        @(negedge clk);
        start = 1'b1; blk_idx = 3'(idx);
        @(negedge clk);
        start = 1'b0;
        while (!seen_done && n < 5000) begin
            @(negedge clk);
            n++;
            if (disturb && n == 100) begin
                start = 1'b1; blk_idx = 3'(idx ^ 1);
                mat_we = 1'b1; mat_addr = 6'd0; mat_data = 16'h1234;
                cf_we = 1'b1;  cf_addr = 6'd9;  cf_data = 16'h7777;
            end else if (disturb && n == 101) begin
                start = 1'b0; mat_we = 1'b0; cf_we = 1'b0;
            end
            if (out_valid) begin
                check(out_idx == 6'(nvalid), {"R6 index ", tname}, out_idx, nvalid);
                check($signed(out_data) == exp_v[out_idx], {"R4 R5 data ", tname},
                      $signed(out_data), exp_v[out_idx]);
                check(out_tag == 2'(exp_tag), {"R7 tag ", tname}, out_tag, exp_tag);
                check(out_blk == 3'(idx), {"R7 blk ", tname}, out_blk, idx);
                nvalid++;
            end
            if (done) seen_done = 1;
        end
        check(seen_done, {"R8 watchdog ", tname}, n, MINC);
        check(n >= MINC, {"R8 latency ", tname}, n, MINC);
        check(nvalid == 64, {"R6 count ", tname}, nvalid, 64);
        @(negedge clk);
        check(!busy && !done, {"R8 idle after done ", tname}, busy, 0);
    endtask

    task automatic t_reset();
        check(!busy, "R1 busy", busy, 0);
        check(!done, "R1 done", done, 0);
        check(!out_valid, "R1 out_valid", out_valid, 0);
    endtask

    task automatic t_identity();
        for (int i = 0; i < 64; i++) begin
            mat_m[i] = ((i / 8) == (i % 8)) ? 16'sd16384 : (((i % 5) == 0) ? 16'sd300 : 16'sd0);
            cf_m[i]  = shortint'(int'($urandom_range(0, 1000)) - 500);
        end
        model();
        load_all();
        run_block(0, 0, "identity");
    endtask

    task automatic t_random();
        for (int i = 0; i < 64; i++) begin
            mat_m[i] = shortint'(int'($urandom_range(0, 16000)) - 8000);
            cf_m[i]  = shortint'(int'($urandom_range(0, 2000)) - 1000);
        end
        model();
        load_all();
        run_block(1, 0, "random");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 64; i++) begin
            mat_m[i] = ((i / 8) == (i % 8)) ? 16'sd32767 : 16'sd0;
            cf_m[i]  = (i % 3 == 0) ? 16'sh8000 : ((i % 3 == 1) ? 16'sd32767 : shortint'(i * 40));
        end
        model();
        load_all();
        run_block(3, 0, "saturate");
    endtask

    task automatic t_busy_ignored();
        for (int i = 0; i < 64; i++) begin
            mat_m[i] = shortint'(int'($urandom_range(0, 20000)) - 10000);
            cf_m[i]  = shortint'(int'($urandom_range(0, 600)) - 300);
        end
        model();
        load_all();
        run_block(5, 1, "R9 start and R2 R3 writes while busy");
        repeat (3) begin
            @(negedge clk);
            check(!busy, "R9 no restart", busy, 0);
        end
        // Rerun with unchanged storage: results must match the original data.
        run_block(7, 0, "R2 R3 storage kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_random();
        t_saturate();
        t_busy_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule